// File: doc/BRIEF.md
# Leaky Bucket Activity Monitor

This block decides whether a timing reference is behaving normally. An upstream detector raises a one-cycle abnormality strobe whenever it sees a fault on the reference. A free-running millisecond tick divides time into fill windows, and each fill window is a programmable number of ticks long. Any fill window that holds at least one strobe adds one to a bucket count. A leak window is a programmable whole number of fill windows. It starts and ends on fill-window boundaries, and each leak window that closes with no strobe in it removes one from the count. Both kinds of window repeat back to back from reset and never overlap.

The count stays between 0 and 64. An activity alarm has two programmable thresholds that give it hysteresis. The alarm sets when the count reaches the set threshold. It clears when the count falls to the clear threshold or below. Between the two thresholds it keeps its state. The window lengths and thresholds are static configuration, and changes are made while the block is held in reset. Detecting the abnormality itself is outside this block.

Top module: `leaky_bucket_monitor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the bucket count is 0 and the alarm is low.
- R2: A fill window lasts `fill_win_i + 1` ticks, so codes 0..15 give 1..16 ms. When a window closes, the count rises by exactly one if one or more strobes fell in that window, however many there were.
- R3: The count never exceeds 64. A dirty fill window that closes while the count is 64 leaves it at 64.
- R4: A leak window lasts `leak_mult_i + 1` consecutive fill windows and closes together with the last of them. When it closes with no strobe anywhere inside it, the count falls by one.
- R5: The count never goes below 0. A clean leak window that closes while the count is 0 leaves it at 0.
- R6: A strobe anywhere inside a leak window cancels that window's decrement.
- R7: A strobe in the same cycle as the tick that closes a window belongs to the window that is closing.
- R8: The set threshold is `thr_set_i + 1`, giving 1..64. The alarm is high in every cycle in which the count is at or above it.
- R9: The clear threshold is `thr_clr_i + 1`, giving 1..64. When the count is at or below it, and below the set threshold, the alarm is low. Between the two thresholds the alarm keeps its previous value.
- R10: The count and the alarm change only in the cycle after a window-closing tick, and the count moves by at most one per cycle.
- R11: If the thresholds overlap so that the count meets both conditions, setting wins and the alarm is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-cycle pulse once per millisecond |
| abn_hit_i | input | 1 | One-cycle abnormality strobe from the detector |
| fill_win_i | input | 4 | Fill window length in ticks, minus one |
| leak_mult_i | input | 4 | Leak window length in fill windows, minus one |
| thr_set_i | input | 6 | Alarm set threshold, minus one |
| thr_clr_i | input | 6 | Alarm clear threshold, minus one |
| bucket_lvl_o | output | 7 | Current bucket count, 0..64 |
| alarm_o | output | 1 | Activity alarm |

## Verification
A fill window can close on the same tick as the leak window that contains it. A strobe can also arrive on that very closing tick, so the increment decision and the leak-clean decision fall in one cycle. The bench provokes this by driving strobes at a pseudo-random density that includes tick cycles, over configurations where the two window lengths are equal and where they differ. Each coincident close is judged against an arithmetic model that places window ends at multiples of the tick count, and the expected outcome is always one increment and no decrement.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

  // Window events produced by the timer for the bucket
  typedef struct packed {
    logic fill_close;  // a fill window ends this cycle
    logic leak_close;  // a leak window ends this cycle
    logic fill_dirty;  // closing fill window saw a strobe
    logic leak_clean;  // closing leak window saw no strobe
  } lbm_evt_t;

  // Threshold code to level: code 0 means level 1
  function automatic int unsigned thr_decode(int unsigned code);
    return code + 1;
  endfunction

  // Saturating bucket step, increment has priority
  function automatic int unsigned bucket_next(int unsigned lvl, bit up,
                                              bit down, int unsigned top);
    if (up && lvl < top)
      return lvl + 1;
    else if (up)
      return lvl;
    else if (down && lvl > 0)
      return lvl - 1;
    return lvl;
  endfunction

  // Hysteresis: set beats clear, otherwise hold
  function automatic bit alarm_next(int unsigned lvl, int unsigned set_lvl,
                                    int unsigned clr_lvl, bit cur);
    if (lvl >= set_lvl)
      return 1'b1;
    else if (lvl <= clr_lvl)
      return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/lbm_window_timer.sv
module lbm_window_timer
  import lbm_pkg::*;
#(
  parameter int unsigned FILL_W = 4,
  parameter int unsigned MULT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              hit_i,
  input  logic [FILL_W-1:0] fill_code_i,
  input  logic [MULT_W-1:0] mult_code_i,
  output lbm_evt_t          evt_o
);

  logic [FILL_W-1:0] fill_cnt_q;
  logic [MULT_W-1:0] leak_cnt_q;
  logic              fill_dirty_q;
  logic              leak_dirty_q;

  logic fill_close;
  logic leak_close;
  logic fill_seen;
  logic leak_seen;

  // a strobe on the closing cycle still belongs to the closing window
  assign fill_seen  = fill_dirty_q | hit_i;
  assign leak_seen  = leak_dirty_q | hit_i;
  assign fill_close = tick_i && (fill_cnt_q >= fill_code_i);
  assign leak_close = fill_close && (leak_cnt_q >= mult_code_i);

  always_comb begin
    evt_o.fill_close = fill_close;
    evt_o.leak_close = leak_close;
    evt_o.fill_dirty = fill_close & fill_seen;
    evt_o.leak_clean = leak_close & ~leak_seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt_q <= '0;
      leak_cnt_q <= '0;
    end else if (tick_i) begin
      if (fill_close) begin
        fill_cnt_q <= '0;
        if (leak_close)
          leak_cnt_q <= '0;
        else
          leak_cnt_q <= leak_cnt_q + 1'b1;
      end else begin
        fill_cnt_q <= fill_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_dirty_q <= 1'b0;
      leak_dirty_q <= 1'b0;
    end else begin
      fill_dirty_q <= fill_close ? 1'b0 : fill_seen;
      leak_dirty_q <= leak_close ? 1'b0 : leak_seen;
    end
  end

endmodule

// File: rtl/lbm_bucket.sv
module lbm_bucket
  import lbm_pkg::*;
#(
  parameter int unsigned LVL_MAX = 64,
  parameter int unsigned LVL_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [LVL_W-1:0] level_d_o,
  output logic [LVL_W-1:0] level_q_o
);

  assign level_d_o = LVL_W'(bucket_next(32'(level_q_o), inc_i, dec_i, LVL_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      level_q_o <= '0;
    else
      level_q_o <= level_d_o;
  end

endmodule

// File: rtl/lbm_alarm.sv
module lbm_alarm
  import lbm_pkg::*;
#(
  parameter int unsigned THR_W = 6,
  parameter int unsigned LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level_d_i,
  input  logic [THR_W-1:0] set_code_i,
  input  logic [THR_W-1:0] clr_code_i,
  output logic             alarm_q_o
);

  logic        alarm_d;
  int unsigned set_lvl;
  int unsigned clr_lvl;

  assign set_lvl = thr_decode(32'(set_code_i));
  assign clr_lvl = thr_decode(32'(clr_code_i));
  assign alarm_d = alarm_next(32'(level_d_i), set_lvl, clr_lvl, alarm_q_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      alarm_q_o <= 1'b0;
    else
      alarm_q_o <= alarm_d;
  end

endmodule

// File: rtl/leaky_bucket_monitor.sv
module leaky_bucket_monitor
  import lbm_pkg::*;
#(
  parameter int unsigned FILL_W  = 4,
  parameter int unsigned MULT_W  = 4,
  parameter int unsigned THR_W   = 6,
  parameter int unsigned LVL_MAX = 64,
  localparam int unsigned LVL_W  = $clog2(LVL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms_i,
  input  logic              abn_hit_i,
  input  logic [FILL_W-1:0] fill_win_i,
  input  logic [MULT_W-1:0] leak_mult_i,
  input  logic [THR_W-1:0]  thr_set_i,
  input  logic [THR_W-1:0]  thr_clr_i,
  output logic [LVL_W-1:0]  bucket_lvl_o,
  output logic              alarm_o
);

  lbm_evt_t         evt;
  logic             fill_close;
  logic             leak_close;
  logic             fill_inc;
  logic             leak_dec;
  logic [LVL_W-1:0] level_d;

  // named internal events, observed by the checker
  assign fill_close = evt.fill_close;
  assign leak_close = evt.leak_close;
  assign fill_inc   = evt.fill_dirty;
  assign leak_dec   = evt.leak_clean;

  lbm_window_timer #(
    .FILL_W (FILL_W),
    .MULT_W (MULT_W)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_ms_i),
    .hit_i       (abn_hit_i),
    .fill_code_i (fill_win_i),
    .mult_code_i (leak_mult_i),
    .evt_o       (evt)
  );

  lbm_bucket #(
    .LVL_MAX (LVL_MAX),
    .LVL_W   (LVL_W)
  ) u_bucket (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_i     (fill_inc),
    .dec_i     (leak_dec),
    .level_d_o (level_d),
    .level_q_o (bucket_lvl_o)
  );

  lbm_alarm #(
    .THR_W (THR_W),
    .LVL_W (LVL_W)
  ) u_alarm (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_d_i  (level_d),
    .set_code_i (thr_set_i),
    .clr_code_i (thr_clr_i),
    .alarm_q_o  (alarm_o)
  );

endmodule

// File: rtl/leaky_bucket_monitor_chk.sv
module leaky_bucket_monitor_chk #(
  parameter int unsigned THR_W   = 6,
  parameter int unsigned LVL_W   = 7,
  parameter int unsigned LVL_MAX = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_ms_i,
  input logic             abn_hit_i,
  input logic [THR_W-1:0] thr_set_i,
  input logic [THR_W-1:0] thr_clr_i,
  input logic [LVL_W-1:0] bucket_lvl_o,
  input logic             alarm_o,
  input logic             fill_close,
  input logic             leak_close,
  input logic             fill_inc,
  input logic             leak_dec
);

  logic [LVL_W-1:0] set_lvl;
  logic [LVL_W-1:0] clr_lvl;
  assign set_lvl = LVL_W'(thr_set_i) + LVL_W'(1);
  assign clr_lvl = LVL_W'(thr_clr_i) + LVL_W'(1);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (bucket_lvl_o == '0 && !alarm_o));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bucket_lvl_o <= LVL_W'(LVL_MAX));

  p_fill_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_inc && bucket_lvl_o < LVL_W'(LVL_MAX)) |=>
      bucket_lvl_o == $past(bucket_lvl_o) + 1'b1);

  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_inc && bucket_lvl_o == LVL_W'(LVL_MAX)) |=> bucket_lvl_o == LVL_W'(LVL_MAX));

  p_leak_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (leak_dec && bucket_lvl_o != '0) |=> bucket_lvl_o == $past(bucket_lvl_o) - 1'b1);

  p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (leak_dec && bucket_lvl_o == '0) |=> bucket_lvl_o == '0);

  p_dirty_leak_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (leak_close && abn_hit_i) |=> bucket_lvl_o >= $past(bucket_lvl_o));

  p_edge_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_close && abn_hit_i && bucket_lvl_o < LVL_W'(LVL_MAX)) |=>
      bucket_lvl_o == $past(bucket_lvl_o) + 1'b1);

  p_alarm_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bucket_lvl_o >= set_lvl |-> alarm_o);

  p_alarm_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bucket_lvl_o <= clr_lvl && bucket_lvl_o < set_lvl) |-> !alarm_o);

  p_tick_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bucket_lvl_o != $past(bucket_lvl_o) || alarm_o != $past(alarm_o)) |->
      $past(tick_ms_i));

  p_unit_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bucket_lvl_o <= $past(bucket_lvl_o) + 1'b1) &&
    (bucket_lvl_o + 1'b1 >= $past(bucket_lvl_o)));

  p_overlap_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bucket_lvl_o >= set_lvl && bucket_lvl_o <= clr_lvl) |-> alarm_o);

endmodule

bind leaky_bucket_monitor leaky_bucket_monitor_chk #(
  .THR_W   (THR_W),
  .LVL_W   (LVL_W),
  .LVL_MAX (LVL_MAX)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_ms_i    (tick_ms_i),
  .abn_hit_i    (abn_hit_i),
  .thr_set_i    (thr_set_i),
  .thr_clr_i    (thr_clr_i),
  .bucket_lvl_o (bucket_lvl_o),
  .alarm_o      (alarm_o),
  .fill_close   (fill_close),
  .leak_close   (leak_close),
  .fill_inc     (fill_inc),
  .leak_dec     (leak_dec)
);

// File: tb/leaky_bucket_monitor_tb.sv
module leaky_bucket_monitor_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       hit = 1'b0;
  logic [3:0] fill_code = '0;
  logic [3:0] mult_code = '0;
  logic [5:0] set_code = '0;
  logic [5:0] clr_code = '0;
  logic [6:0] lvl;
  logic       alarm;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  int    m_level, m_tc, m_f, m_l, m_set, m_clr;
  bit    m_alarm, m_fhit, m_lhit;
  string m_req;
  int    cyc;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  leaky_bucket_monitor u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_ms_i    (tick),
    .abn_hit_i    (hit),
    .fill_win_i   (fill_code),
    .leak_mult_i  (mult_code),
    .thr_set_i    (set_code),
    .thr_clr_i    (clr_code),
    .bucket_lvl_o (lvl),
    .alarm_o      (alarm)
  );

  task automatic check(input string req, input int got, input int exp, input string what);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic string alarm_req();
    if (m_level >= m_set && m_level <= m_clr) return "R11";
    if (m_alarm) return "R8";
    return "R9";
  endfunction

  // arithmetic model: windows end at tick counts that are multiples of their length
  task automatic model(input bit h, input bit t);
    bit fend, lend, grew;
    grew = 0;
    if (t) m_tc++;
    fend = t && (m_tc % m_f == 0);
    lend = t && (m_tc % (m_f * m_l) == 0);
    m_fhit |= h;
    m_lhit |= h;
    m_req = "R10";
    if (fend) begin
      if (m_fhit) begin
        if (m_level < 64) begin
          m_level++;
          grew = 1;
          m_req = h ? "R7" : "R2";
        end else m_req = "R3";
      end
      m_fhit = 0;
    end
    if (lend) begin
      if (!m_lhit) begin
        if (m_level > 0) begin
          m_level--;
          m_req = "R4";
        end else m_req = "R5";
      end else if (!grew) m_req = "R6";
      m_lhit = 0;
    end
    if (m_level >= m_set) m_alarm = 1;
    else if (m_level <= m_clr) m_alarm = 0;
  endtask

  task automatic step(input bit h);
    bit t;
    @(negedge clk);
    check(m_req, int'(lvl), m_level, "bucket count");
    check(alarm_req(), int'(alarm), int'(m_alarm), "alarm");
    t = (cyc % 3 == 0);
    cyc++;
    hit = h;
    tick = t;
    model(h, t);
  endtask

  task automatic start(input int f, input int l, input int a, input int d);
    @(negedge clk);
    rst_n = 0;
    hit = 0;
    tick = 0;
    fill_code = 4'(f - 1);
    mult_code = 4'(l - 1);
    set_code  = 6'(a - 1);
    clr_code  = 6'(d - 1);
    repeat (2) @(negedge clk);
    check("R1", int'(lvl), 0, "count in reset");
    check("R1", int'(alarm), 0, "alarm in reset");
    rst_n = 1;
    m_level = 0; m_tc = 0; m_alarm = 0; m_fhit = 0; m_lhit = 0;
    m_f = f; m_l = l; m_set = a; m_clr = d;
    m_req = "R1";
    cyc = 1;
  endtask

  task automatic run_cfg(input int f, input int l, input int a, input int d);
    start(f, l, a, d);
    // dense strobes: fill to saturation
    repeat (3 * 70 * f) step(1'b1);
    // silence: drain to the floor and beyond
    repeat (3 * 70 * f * l) step(1'b0);
    // sparse and very sparse strobes, including on closing ticks
    for (int i = 0; i < 3 * 15 * f * l; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[2:0] == 3'd0);
    end
    for (int i = 0; i < 3 * 15 * f * l; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[5:0] == 6'd0);
    end
    step(1'b0);
  endtask

  initial begin
    run_cfg(1, 1, 64, 63);   // R3 saturation with alarm only at the top
    run_cfg(2, 3, 5, 2);     // hysteresis band R8 R9
    run_cfg(16, 1, 1, 1);    // equal thresholds, long fill window R11
    run_cfg(1, 16, 10, 20);  // overlapping thresholds, long leak window R11
    run_cfg(3, 2, 32, 8);
    run_cfg(4, 4, 3, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule